// File: doc/BRIEF.md
# Multi-level page table walker

This block turns a 64-bit virtual address into a real address by reading up to five levels of translation tables through a single memory read port. A request carries the virtual address, an access kind, an address-space selector and a translation-enable bit. The block picks one of three root descriptors from the selector and the access kind. A type field in that root decides which table level the walk starts at. Before any table read, a range check confirms that the address fits the depth that was chosen. The walk then reads one entry per level and ends with a page-table entry.

Each request ends with a one-cycle `done` pulse. Either `ok` is high, with a real address and read/write/execute permission bits, or `ok` is low, with an exception code and a translation-exception word. A real address below 0x2000 is moved up by adding the prefix base.

The control is a five-state machine:
- IDLE: accepts a request. If translation is off it goes to DONE; otherwise it goes to RANGE.
- RANGE: goes to DONE with a specification fault, or to ISSUE.
- ISSUE: drives one read and goes to WAIT.
- WAIT: waits for the read data. It goes to ISSUE for the next level, or to DONE on a fault or a final page entry.
- DONE: pulses `done` and returns to IDLE.

Top module: `pt_walk_unit`

## Requirements
- R1: Root selection and accepted encodings.
  - A request is accepted when `req_valid` is high and `busy` is low.
  - `req_space` selects the root: 00 and 01 pick `root_pri`, 10 picks `root_sec`, 11 picks `root_home`.
  - Under 10, a fetch (`req_kind`=10) walks `root_pri`. Reads (00) and writes (01) walk `root_sec`.
- R2: Walk depth and table origins.
  - Root bits 3:2 give the first table: 11 region-first, 10 region-second, 01 region-third, 00 segment.
  - Each level reads one 8-byte entry at origin plus offset, and the walk ends with a page-table read.
  - Root and region entries supply origin bits 63:12. Segment entries supply origin bits 63:11.
- R3: Byte offsets into each table, with `va` the page-aligned address:
  - region-first table: (va>>50)&0x3FF8
  - region-second table: (va>>39)&0x3FF8
  - region-third table: (va>>28)&0x3FF8
  - segment table: (va>>17)&0x3FF8
  - page table: (va>>9)&0x7F8
- R4: Range checks before the walk. A nonzero va[63:53] under a region-second root, va[63:42] under a region-third root, or va[63:31] under a segment root gives code 0x12. No memory read is made.
- R5: Region and segment entry faults.
  - A region or segment entry with bit 5 set gives code 0x10.
  - A region entry's bits 3:2 must name the next level: 10 in the region-first table, 01 in region-second, 00 in region-third. Any other value gives code 0x12.
- R6: Page entry handling.
  - A page entry with bit 10 set gives code 0x11.
  - Bit 9 marks the page read-only and clears write permission.
  - The real address is entry bits 63:12 with the low 12 bits zero.
- R7: A write to a read-only page gives code 0x04. Its exception word is the page-aligned va ORed with the space bits and 4.
- R8: With `xlate_en` low, the page-aligned va is the real address, `perm` is 111, and `done` pulses in the cycle after acceptance.
- R9: Under selector 10, a fetch returns permission 001 (execute only). Reads and writes return 110 (read and write, no execute).
- R10: A real address below 0x2000, whether translated or passed through, has `prefix_base` added to it.
- R11: Result signalling.
  - `done` is a one-cycle pulse.
  - With `ok`=1, `exc_code` is 0. With `ok`=0, `exc_code` is nonzero.
  - The fault word is the page-aligned va ORed with the space bits of the root actually walked: primary 0, secondary 2, home 3.
  - `perm` bit 2 is read, bit 1 is write, bit 0 is execute.
- R12: `mem_rd_req` is a one-cycle pulse, raised only while busy. The next read waits for `mem_rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_va | input | AW | Virtual address |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch |
| req_space | input | 2 | Address-space selector |
| xlate_en | input | 1 | Translation enable |
| root_pri | input | AW | Primary root descriptor |
| root_sec | input | AW | Secondary root descriptor |
| root_home | input | AW | Home root descriptor |
| prefix_base | input | AW | Relocation base for low real addresses |
| busy | output | 1 | Walk in progress |
| mem_rd_req | output | 1 | Table read request |
| mem_rd_addr | output | AW | Table entry address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | AW | Table entry data |
| done | output | 1 | Result pulse |
| ok | output | 1 | Translation succeeded |
| real_addr | output | AW | Real address |
| perm | output | 3 | Read, write, execute permission |
| exc_code | output | 8 | Exception code |
| exc_word | output | AW | Translation-exception word |

## Verification
The hardest situations to reach from the ports are faults deep inside a long walk. Examples are a region entry with the wrong type three levels down a five-level walk, and the split under selector 10, where fetches and data accesses walk different roots. The bench first builds a complete, valid table image in its memory model for a chosen start level and address. It then corrupts exactly one entry, so each walk reaches the intended level before it fails. For the split, separate primary and secondary images are built, each pointing at a different frame.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [2:0] {S_IDLE, S_RANGE, S_ISSUE, S_WAIT, S_DONE} ptw_state_e;

    localparam int PAGE_BITS  = 12;
    localparam int SEG_ORG_LO = 11;
    localparam int CHK_R2_LO  = 53;
    localparam int CHK_R3_LO  = 42;
    localparam int CHK_SG_LO  = 31;
    localparam logic [63:0] LOW_LIMIT = 64'h2000;

    localparam logic [2:0] LV_PAGE = 3'd0;
    localparam logic [2:0] LV_SEG  = 3'd1;
    localparam logic [2:0] LV_R3   = 3'd2;
    localparam logic [2:0] LV_R2   = 3'd3;
    localparam logic [2:0] LV_R1   = 3'd4;

    localparam logic [7:0] EXC_PROT = 8'h04;
    localparam logic [7:0] EXC_SEG  = 8'h10;
    localparam logic [7:0] EXC_PAGE = 8'h11;
    localparam logic [7:0] EXC_SPEC = 8'h12;

    localparam logic [1:0] KIND_WRITE = 2'b01;
    localparam logic [1:0] KIND_FETCH = 2'b10;
    localparam logic [1:0] SPC_SEC    = 2'b10;
    localparam logic [1:0] SPC_HOME   = 2'b11;

    localparam int BIT_INVALID = 5;
    localparam int BIT_PG_INV  = 10;
    localparam int BIT_PG_RO   = 9;
endpackage

// File: rtl/ptw_index.sv
module ptw_index import ptw_pkg::*; #(
    parameter int AW = 64
) (
    input  logic [2:0]    level,
    input  logic [AW-1:0] va,
    output logic [AW-1:0] offset
);
    localparam logic [AW-1:0] RMASK = AW'(64'h3FF8);
    localparam logic [AW-1:0] PMASK = AW'(64'h07F8);

    always_comb begin
        unique case (level)
            LV_R1:   offset = (va >> 50) & RMASK;
            LV_R2:   offset = (va >> 39) & RMASK;
            LV_R3:   offset = (va >> 28) & RMASK;
            LV_SEG:  offset = (va >> 17) & RMASK;
            default: offset = (va >> 9)  & PMASK;
        endcase
    end
endmodule

// File: rtl/ptw_decode.sv
module ptw_decode import ptw_pkg::*; #(
    parameter int AW = 64
) (
    input  logic [2:0]    level,
    input  logic [AW-1:0] entry,
    input  logic          is_write,
    output logic          fault,
    output logic [7:0]    code,
    output logic [AW-1:0] next_origin,
    output logic          last,
    output logic          ro
);
    always_comb begin
        fault       = 1'b0;
        code        = 8'h00;
        last        = 1'b0;
        ro          = 1'b0;
        next_origin = {entry[AW-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
        if (level >= LV_R3) begin
            if (entry[BIT_INVALID]) begin
                fault = 1'b1;
                code  = EXC_SEG;
            end else if (entry[3:2] != 2'(level - 3'd2)) begin
                fault = 1'b1;
                code  = EXC_SPEC;
            end
        end else if (level == LV_SEG) begin
            next_origin = {entry[AW-1:SEG_ORG_LO], {SEG_ORG_LO{1'b0}}};
            if (entry[BIT_INVALID]) begin
                fault = 1'b1;
                code  = EXC_SEG;
            end
        end else begin
            last = 1'b1;
            ro   = entry[BIT_PG_RO];
            if (entry[BIT_PG_INV]) begin
                fault = 1'b1;
                code  = EXC_PAGE;
            end else if (entry[BIT_PG_RO] && is_write) begin
                fault = 1'b1;
                code  = EXC_PROT;
            end
        end
    end
endmodule

// File: rtl/ptw_reloc.sv
module ptw_reloc import ptw_pkg::*; #(
    parameter int AW = 64
) (
    input  logic [AW-1:0] raw,
    input  logic [AW-1:0] prefix,
    output logic [AW-1:0] relocated
);
    localparam logic [AW-1:0] LIMIT = AW'(LOW_LIMIT);

    always_comb relocated = (raw < LIMIT) ? raw + prefix : raw;
endmodule

// File: rtl/pt_walk_unit.sv
module pt_walk_unit import ptw_pkg::*; #(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_va,
    input  logic [1:0]    req_kind,
    input  logic [1:0]    req_space,
    input  logic          xlate_en,
    input  logic [AW-1:0] root_pri,
    input  logic [AW-1:0] root_sec,
    input  logic [AW-1:0] root_home,
    input  logic [AW-1:0] prefix_base,
    output logic          busy,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_valid,
    input  logic [AW-1:0] mem_rd_data,
    output logic          done,
    output logic          ok,
    output logic [AW-1:0] real_addr,
    output logic [2:0]    perm,
    output logic [7:0]    exc_code,
    output logic [AW-1:0] exc_word
);
    localparam logic [AW-1:0] PG_MASK = ~AW'((64'd1 << PAGE_BITS) - 1);

    ptw_state_e    state;
    logic [AW-1:0] va_q, root_q, origin_q, real_q, word_q;
    logic [2:0]    level_q, perm_q, mask_q;
    logic [1:0]    spc_q;
    logic          write_q, ok_q;
    logic [7:0]    code_q;

    logic [AW-1:0] offset, dec_next, reloc_in, reloc_out, sel_root;
    logic          dec_fault, dec_last, dec_ro, range_bad, use_pri;
    logic [7:0]    dec_code;
    logic [1:0]    sel_bits;
    logic [2:0]    sel_mask;

    ptw_index #(.AW(AW)) u_index (.level(level_q), .va(va_q), .offset(offset));

    ptw_decode #(.AW(AW)) u_decode (
        .level(level_q), .entry(mem_rd_data), .is_write(write_q),
        .fault(dec_fault), .code(dec_code), .next_origin(dec_next),
        .last(dec_last), .ro(dec_ro)
    );

    assign reloc_in = (state == S_IDLE) ? (req_va & PG_MASK) : (mem_rd_data & PG_MASK);

    ptw_reloc #(.AW(AW)) u_reloc (.raw(reloc_in), .prefix(prefix_base), .relocated(reloc_out));

    always_comb begin
        use_pri = (req_space[1] == 1'b0) || (req_space == SPC_SEC && req_kind == KIND_FETCH);
        if (use_pri) begin
            sel_root = root_pri;
            sel_bits = 2'b00;
        end else if (req_space == SPC_HOME) begin
            sel_root = root_home;
            sel_bits = 2'b11;
        end else begin
            sel_root = root_sec;
            sel_bits = 2'b10;
        end
        if (req_space == SPC_SEC)
            sel_mask = (req_kind == KIND_FETCH) ? 3'b001 : 3'b110;
        else
            sel_mask = 3'b111;
    end

    always_comb begin
        unique case (root_q[3:2])
            2'b11:   range_bad = 1'b0;
            2'b10:   range_bad = |(va_q >> CHK_R2_LO);
            2'b01:   range_bad = |(va_q >> CHK_R3_LO);
            default: range_bad = |(va_q >> CHK_SG_LO);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            va_q     <= '0;
            root_q   <= '0;
            origin_q <= '0;
            real_q   <= '0;
            word_q   <= '0;
            level_q  <= LV_PAGE;
            perm_q   <= '0;
            mask_q   <= '0;
            spc_q    <= '0;
            write_q  <= 1'b0;
            ok_q     <= 1'b0;
            code_q   <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    va_q    <= req_va & PG_MASK;
                    write_q <= (req_kind == KIND_WRITE);
                    root_q  <= sel_root;
                    spc_q   <= sel_bits;
                    mask_q  <= sel_mask;
                    if (!xlate_en) begin
                        ok_q   <= 1'b1;
                        code_q <= '0;
                        word_q <= '0;
                        real_q <= reloc_out;
                        perm_q <= 3'b111;
                        state  <= S_DONE;
                    end else begin
                        state <= S_RANGE;
                    end
                end
                S_RANGE: if (range_bad) begin
                    ok_q   <= 1'b0;
                    code_q <= EXC_SPEC;
                    word_q <= va_q | AW'(spc_q);
                    state  <= S_DONE;
                end else begin
                    level_q  <= {1'b0, root_q[3:2]} + 3'd1;
                    origin_q <= root_q & PG_MASK;
                    state    <= S_ISSUE;
                end
                S_ISSUE: state <= S_WAIT;
                S_WAIT: if (mem_rd_valid) begin
                    if (dec_fault) begin
                        ok_q   <= 1'b0;
                        code_q <= dec_code;
                        word_q <= va_q | AW'(spc_q) | ((dec_code == EXC_PROT) ? AW'(4) : AW'(0));
                        state  <= S_DONE;
                    end else if (dec_last) begin
                        ok_q   <= 1'b1;
                        code_q <= '0;
                        word_q <= '0;
                        real_q <= reloc_out;
                        perm_q <= mask_q & {1'b1, ~dec_ro, 1'b1};
                        state  <= S_DONE;
                    end else begin
                        level_q  <= level_q - 3'd1;
                        origin_q <= dec_next;
                        state    <= S_ISSUE;
                    end
                end
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy        = (state != S_IDLE);
        mem_rd_req  = (state == S_ISSUE);
        mem_rd_addr = origin_q + offset;
        done        = (state == S_DONE);
        ok          = ok_q;
        real_addr   = real_q;
        perm        = perm_q;
        exc_code    = code_q;
        exc_word    = word_q;
    end
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       xlate_en,
    input logic       busy,
    input logic       mem_rd_req,
    input logic       mem_rd_valid,
    input logic       done,
    input logic       ok,
    input logic [2:0] perm,
    input logic [7:0] exc_code
);
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_ok_nocode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok) |-> (exc_code == 8'h00));
    assert_fail_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ok) |-> (exc_code != 8'h00));
    assert_read_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);
    assert_read_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> busy);
    assert_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !xlate_en) |=> (done && ok && perm == 3'b111));
    assert_done_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_rd_req);
    assert_valid_seen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> !done);
endmodule

bind pt_walk_unit ptw_checker u_ptw_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .xlate_en(xlate_en),
    .busy(busy), .mem_rd_req(mem_rd_req), .mem_rd_valid(mem_rd_valid),
    .done(done), .ok(ok), .perm(perm), .exc_code(exc_code)
);

// File: tb/pt_walk_unit_test.sv
`timescale 1ns/1ps
module pt_walk_unit_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [63:0] req_va = '0;
    logic [1:0] req_kind = '0, req_space = '0;
    logic xlate_en = 1'b0;
    logic [63:0] root_pri = '0, root_sec = '0, root_home = '0, prefix_base = '0;
    logic busy, mem_rd_req, done, ok;
    logic [63:0] mem_rd_addr, real_addr, exc_word;
    logic mem_rd_valid = 1'b0;
    logic [63:0] mem_rd_data = '0;
    logic [2:0] perm;
    logic [7:0] exc_code;

    int checks = 0, failures = 0, rd_cnt = 0;

    typedef struct packed {
        logic        ok;
        logic [63:0] ra;
        logic [2:0]  perm;
        logic [7:0]  code;
        logic [63:0] word;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    logic [63:0] mem [logic [63:0]];

    always #2.5 clk = ~clk;

    pt_walk_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_kind(req_kind), .req_space(req_space), .xlate_en(xlate_en),
        .root_pri(root_pri), .root_sec(root_sec), .root_home(root_home),
        .prefix_base(prefix_base), .busy(busy), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .done(done), .ok(ok), .real_addr(real_addr),
        .perm(perm), .exc_code(exc_code), .exc_word(exc_word)
    );

    always @(posedge clk) begin
        mem_rd_valid <= 1'b0;
        if (mem_rd_req) begin
            mem_rd_valid <= 1'b1;
            mem_rd_data  <= mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 64'h0;
            rd_cnt       <= rd_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && done) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R11 unexpected done: actual ok=%0b expected none", ok);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e.ok) begin
                    if (!ok || real_addr !== e.ra || perm !== e.perm) begin
                        failures++;
                        $display("FAIL %s: actual ok=%0b ra=%h perm=%b code=%h expected ra=%h perm=%b",
                                 t, ok, real_addr, perm, exc_code, e.ra, e.perm);
                    end
                end else if (ok || exc_code !== e.code || exc_word !== e.word) begin
                    failures++;
                    $display("FAIL %s: actual ok=%0b code=%h word=%h expected code=%h word=%h",
                             t, ok, exc_code, exc_word, e.code, e.word);
                end
            end
        end
    end

    function automatic exp_t okx(input logic [63:0] ra, input logic [2:0] p);
        exp_t e;
        e = '{ok: 1'b1, ra: ra, perm: p, code: 8'h0, word: 64'h0};
        return e;
    endfunction

    function automatic exp_t flt(input logic [7:0] c, input logic [63:0] w);
        exp_t e;
        e = '{ok: 1'b0, ra: 64'h0, perm: 3'b0, code: c, word: w};
        return e;
    endfunction

    function automatic logic [63:0] tb_off(input int l, input logic [63:0] va);
        case (l)
            4: return (va >> 50) & 64'h3FF8;
            3: return (va >> 39) & 64'h3FF8;
            2: return (va >> 28) & 64'h3FF8;
            1: return (va >> 17) & 64'h3FF8;
            default: return (va >> 9) & 64'h7F8;
        endcase
    endfunction

    function automatic logic [63:0] tbl(input logic [63:0] base, input int l);
        return base + 64'(l) * 64'h10000;
    endfunction

    function automatic logic [63:0] root_of(input logic [63:0] base, input int start);
        return tbl(base, start) | (64'(start - 1) << 2);
    endfunction

    task automatic build(input logic [63:0] va, input int start,
                         input logic [63:0] base, input logic [63:0] pte);
        for (int l = start; l >= 1; l--) begin
            logic [63:0] a;
            a = tbl(base, l) + tb_off(l, va);
            if (l >= 2) mem[a] = tbl(base, l - 1) | (64'(l - 2) << 2);
            else        mem[a] = tbl(base, 0);
        end
        mem[tbl(base, 0) + tb_off(0, va)] = pte;
    endtask

    task automatic chk(input logic cond, input string tag,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic run(input string tag, input logic [63:0] va, input logic [1:0] kind,
                       input logic [1:0] spc, input logic en, input exp_t e);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        req_va = va; req_kind = kind; req_space = spc; xlate_en = en; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        failures++;
        $display("FAIL watchdog: actual running expected finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] va, b;
        int n0;
        repeat (3) @(negedge clk);
        chk(!done && !busy && !mem_rd_req, "R11 reset idle", {61'b0, done, busy, mem_rd_req}, 64'h0);
        rst_n = 1'b1;
        prefix_base = 64'h0040_0000;

        // R8 pass-through, R10 prefix on pass-through
        run("R8 passthru write", 64'h0000_1234_5678_9ABC, 2'b01, 2'b00, 1'b0,
            okx(64'h0000_1234_5678_9000, 3'b111));
        run("R10 passthru low", 64'h1F00, 2'b00, 2'b00, 1'b0, okx(64'h0040_1000, 3'b111));

        // R1 R2 R3 segment root, primary read
        va = 64'h0000_0000_1234_5000; b = 64'h0010_0000;
        mem.delete(); build(va, 1, b, 64'h0ABC_D000); root_pri = root_of(b, 1);
        n0 = rd_cnt;
        run("R2 R3 segment walk", va, 2'b00, 2'b00, 1'b1, okx(64'h0ABC_D000, 3'b111));
        chk(rd_cnt - n0 == 2, "R2 segment read count", 64'(rd_cnt - n0), 64'd2);
        run("R1 space 01 as primary", va, 2'b00, 2'b01, 1'b1, okx(64'h0ABC_D000, 3'b111));

        // R6 read-only, R7 protection
        mem[tbl(b, 0) + tb_off(0, va)] = 64'h0ABC_D200;
        run("R6 read-only read", va, 2'b00, 2'b00, 1'b1, okx(64'h0ABC_D000, 3'b101));
        run("R7 write protect primary", va, 2'b01, 2'b00, 1'b1, flt(8'h04, va | 64'h4));
        root_home = root_pri; root_pri = 64'h0;
        run("R7 R1 write protect home", va, 2'b01, 2'b11, 1'b1, flt(8'h04, va | 64'h7));
        root_pri = root_home;

        // R6 page invalid, R5 segment invalid
        mem[tbl(b, 0) + tb_off(0, va)] = 64'h0ABC_D400;
        run("R6 page invalid", va, 2'b00, 2'b00, 1'b1, flt(8'h11, va));
        mem[tbl(b, 0) + tb_off(0, va)] = 64'h0ABC_D000;
        mem[tbl(b, 1) + tb_off(1, va)] = tbl(b, 0) | 64'h20;
        run("R5 segment invalid", va, 2'b00, 2'b00, 1'b1, flt(8'h10, va));

        // R4 segment range
        n0 = rd_cnt;
        run("R4 segment range", 64'h0000_0000_8000_0000, 2'b00, 2'b00, 1'b1,
            flt(8'h12, 64'h0000_0000_8000_0000));
        chk(rd_cnt == n0, "R4 no read on range fault", 64'(rd_cnt - n0), 64'd0);

        // R2 R3 five-level walk
        va = 64'h1234_5678_9ABC_D000; b = 64'h0100_0000;
        mem.delete(); build(va, 4, b, 64'h7777_7000); root_pri = root_of(b, 4);
        n0 = rd_cnt;
        run("R2 R3 region-first walk", va, 2'b10, 2'b00, 1'b1, okx(64'h7777_7000, 3'b111));
        chk(rd_cnt - n0 == 5, "R2 five reads", 64'(rd_cnt - n0), 64'd5);
        mem[tbl(b, 2) + tb_off(2, va)] = tbl(b, 1) | 64'h4;
        run("R5 region-third entry type", va, 2'b00, 2'b00, 1'b1, flt(8'h12, va));
        mem[tbl(b, 2) + tb_off(2, va)] = tbl(b, 1);
        mem[tbl(b, 3) + tb_off(3, va)] = tbl(b, 2) | 64'h24;
        run("R5 region invalid", va, 2'b00, 2'b00, 1'b1, flt(8'h10, va));

        // R4 region-second and region-third range
        b = 64'h0200_0000; mem.delete();
        va = 64'h0010_0000_0000_3000;
        build(va, 3, b, 64'h0055_5000); root_pri = root_of(b, 3);
        run("R4 region-second bit52 ok", va, 2'b00, 2'b00, 1'b1, okx(64'h0055_5000, 3'b111));
        run("R4 region-second bit53", 64'h0020_0000_0000_0000, 2'b00, 2'b00, 1'b1,
            flt(8'h12, 64'h0020_0000_0000_0000));
        va = 64'h0000_0200_0000_4000;
        build(va, 2, b, 64'h0066_6000); root_pri = root_of(b, 2);
        run("R4 region-third bit41 ok", va, 2'b00, 2'b00, 1'b1, okx(64'h0066_6000, 3'b111));
        run("R4 region-third bit42", 64'h0000_0400_0000_0000, 2'b00, 2'b00, 1'b1,
            flt(8'h12, 64'h0000_0400_0000_0000));

        // R1 R9 secondary split
        va = 64'h0000_0000_0123_4000; mem.delete();
        build(va, 1, 64'h0300_0000, 64'h0AAA_A000); root_pri = root_of(64'h0300_0000, 1);
        build(va, 1, 64'h0400_0000, 64'h0BBB_B000); root_sec = root_of(64'h0400_0000, 1);
        run("R9 R1 secondary fetch", va, 2'b10, 2'b10, 1'b1, okx(64'h0AAA_A000, 3'b001));
        run("R9 R1 secondary read", va, 2'b00, 2'b10, 1'b1, okx(64'h0BBB_B000, 3'b110));
        mem[tbl(64'h0400_0000, 0) + tb_off(0, va)] = 64'h0BBB_B400;
        run("R11 secondary fault bits", va, 2'b01, 2'b10, 1'b1, flt(8'h11, va | 64'h2));
        run("R11 secondary fetch primary bits", va, 2'b10, 2'b10, 1'b1, okx(64'h0AAA_A000, 3'b001));

        // R10 relocation after walk
        mem[tbl(64'h0300_0000, 0) + tb_off(0, va)] = 64'h1000;
        run("R10 walk low frame", va, 2'b00, 2'b00, 1'b1, okx(64'h0040_1000, 3'b111));
        mem[tbl(64'h0300_0000, 0) + tb_off(0, va)] = 64'h2000;
        run("R10 walk frame at limit", va, 2'b00, 2'b00, 1'b1, okx(64'h2000, 3'b111));

        repeat (3) @(negedge clk);
        chk(!done && !busy, "R11 idle after runs", {62'b0, done, busy}, 64'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule